// File: doc/BRIEF.md
# Request-Grant Single-Beat Bus Master

This block sits between a local client and a simple shared bus. The client asks for one read or one write by pulsing a request with an 8-bit address and, for a write, a 64-bit data word. The block then runs a fixed bus sequence. It pulses a bus request for one cycle and expects a grant in the following cycle. It issues a single read or write strobe in the cycle after the grant. It then drives the address, flagged as valid, in the next cycle. In that same cycle a write puts its data beat on the bus, and a read takes its returned beat from the bus.

Each stage is exactly one cycle after the one before it. Nothing in the sequence can stretch. If the grant does not arrive in its slot, the block abandons the attempt, waits one idle cycle and requests again, keeping the operation. Only one operation runs at a time, and a busy output tells the client when requests will be ignored. A read captures its returned beat into a read buffer that the client can see. Every finished beat raises a one-cycle done pulse.

Top module: `rgm_master`

## Requirements
- R1: After reset, all bus outputs, `loc_busy` and `loc_done` are 0, and `rd_buf` is 0.
- R2: `bus_req` is high for one cycle only and is never high in two consecutive cycles.
- R3: A read or write strobe is high only in the cycle right after a cycle in which `bus_gnt` was high, and that cycle in turn followed a cycle with `bus_req` high.
- R4: `bus_rd` and `bus_wr` are never high together.
- R5: `bus_addr_vld` is high exactly in the cycle after a read or write strobe. In that cycle `bus_addr` carries the address of the operation.
- R6: `bus_wdata_vld` is high exactly in the cycle after `bus_wr`. In that cycle `bus_wdata` carries the data of the write.
- R7: In the cycle after `bus_rd`, a beat on `bus_rdata` with `bus_rdata_vld` high is stored in `rd_buf`. The stored value is visible from the next cycle on.
- R8: If `bus_gnt` is low in the cycle after `bus_req`, no strobe follows. `bus_req` pulses again two cycles later, and the same operation is carried out.
- R9: While `loc_busy` is high, local requests are ignored and cause no bus transfer. `loc_busy` goes high in the cycle after a request is accepted.
- R10: When read and write requests arrive in the same cycle, the read runs on the bus first. The write is kept and runs next, before `loc_busy` falls.
- R11: `loc_done` is high for exactly the cycle after each cycle with `bus_addr_vld` high, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_rd_req | input | 1 | Local read request (one cycle) |
| loc_rd_addr | input | 8 | Local read address |
| loc_wr_req | input | 1 | Local write request (one cycle) |
| loc_wr_addr | input | 8 | Local write address |
| loc_wr_data | input | 64 | Local write data |
| loc_busy | output | 1 | Operation in progress; requests ignored |
| loc_done | output | 1 | One-cycle completion pulse |
| rd_buf | output | 64 | Last captured read beat |
| bus_req | output | 1 | Bus request pulse |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read command strobe |
| bus_wr | output | 1 | Write command strobe |
| bus_addr | output | 8 | Bus address |
| bus_addr_vld | output | 1 | Address valid |
| bus_wdata | output | 64 | Write data beat |
| bus_wdata_vld | output | 1 | Write data valid |
| bus_rdata | input | 64 | Read data beat |
| bus_rdata_vld | input | 1 | Read data valid |

## Verification
The assertions check the cycle-by-cycle protocol on every cycle. This covers the single-cycle request pulse, a strobe only after a granted request, mutually exclusive strobes, address and write-data flags exactly one cycle after the strobe, the retry pulse after a missing grant, the done pulse tracking each beat, and capture of the read beat. Other behaviour depends on what the client asked for, so only the bench scenarios can show it. These are: which address and data land on the bus, that a read issued together with a write goes first and the write still follows, that requests made while busy vanish, and that a retried operation still completes with its original contents.

// File: rtl/rgm_pkg.sv
package rgm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_GNT   = 3'd2,
    ST_CMD   = 3'd3,
    ST_BEAT  = 3'd4,
    ST_RETRY = 3'd5
  } rgm_state_t;
endpackage

// File: rtl/rgm_hold.sv
module rgm_hold #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          advance,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cur_is_wr,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_data,
  output logic          defer_vld
);
  logic          cur_is_wr_d;
  logic [AW-1:0] cur_addr_d;
  logic [DW-1:0] cur_data_d;
  logic          defer_vld_d;
  logic [AW-1:0] defer_addr_q, defer_addr_d;
  logic [DW-1:0] defer_data_q, defer_data_d;
  logic          cur_en, defer_en;

  always_comb begin
    cur_en       = 1'b0;
    defer_en     = 1'b0;
    cur_is_wr_d  = cur_is_wr;
    cur_addr_d   = cur_addr;
    cur_data_d   = cur_data;
    defer_vld_d  = defer_vld;
    defer_addr_d = defer_addr_q;
    defer_data_d = defer_data_q;
    if (accept) begin
      cur_en   = 1'b1;
      defer_en = 1'b1;
      if (rd_req) begin
        cur_is_wr_d  = 1'b0;
        cur_addr_d   = rd_addr;
        cur_data_d   = '0;
        defer_vld_d  = wr_req;
        defer_addr_d = wr_addr;
        defer_data_d = wr_data;
      end else begin
        cur_is_wr_d  = 1'b1;
        cur_addr_d   = wr_addr;
        cur_data_d   = wr_data;
        defer_vld_d  = 1'b0;
      end
    end else if (advance && defer_vld) begin
      cur_en      = 1'b1;
      defer_en    = 1'b1;
      cur_is_wr_d = 1'b1;
      cur_addr_d  = defer_addr_q;
      cur_data_d  = defer_data_q;
      defer_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_is_wr <= 1'b0;
      cur_addr  <= '0;
      cur_data  <= '0;
    end else if (cur_en) begin
      cur_is_wr <= cur_is_wr_d;
      cur_addr  <= cur_addr_d;
      cur_data  <= cur_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_vld    <= 1'b0;
      defer_addr_q <= '0;
      defer_data_q <= '0;
    end else if (defer_en) begin
      defer_vld    <= defer_vld_d;
      defer_addr_q <= defer_addr_d;
      defer_data_q <= defer_data_d;
    end
  end
endmodule

// File: rtl/rgm_fsm.sv
module rgm_fsm
  import rgm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       gnt,
  input  logic       defer_vld,
  output rgm_state_t state,
  output logic       accept,
  output logic       advance
);
  rgm_state_t state_d;

  assign accept  = (state == ST_IDLE) && start;
  assign advance = (state == ST_BEAT);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (start) state_d = ST_REQ;
      ST_REQ:   state_d = ST_GNT;
      ST_GNT:   state_d = gnt ? ST_CMD : ST_RETRY;
      ST_RETRY: state_d = ST_REQ;
      ST_CMD:   state_d = ST_BEAT;
      ST_BEAT:  state_d = defer_vld ? ST_REQ : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/rgm_bus_drv.sv
module rgm_bus_drv
  import rgm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rgm_state_t    state,
  input  logic          cur_is_wr,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_data,
  input  logic [DW-1:0] rdata,
  input  logic          rdata_vld,
  output logic          req,
  output logic          rd,
  output logic          wr,
  output logic [AW-1:0] addr,
  output logic          addr_vld,
  output logic [DW-1:0] wdata,
  output logic          wdata_vld,
  output logic          done,
  output logic [DW-1:0] rbuf
);
  logic in_beat, cap_en;

  assign in_beat   = (state == ST_BEAT);
  assign req       = (state == ST_REQ);
  assign rd        = (state == ST_CMD) && !cur_is_wr;
  assign wr        = (state == ST_CMD) &&  cur_is_wr;
  assign addr_vld  = in_beat;
  assign addr      = in_beat ? cur_addr : '0;
  assign wdata_vld = in_beat && cur_is_wr;
  assign wdata     = (in_beat && cur_is_wr) ? cur_data : '0;
  assign cap_en    = in_beat && !cur_is_wr && rdata_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= in_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rbuf <= '0;
    else if (cap_en) rbuf <= rdata;
  end
endmodule

// File: rtl/rgm_master.sv
module rgm_master
  import rgm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_rd_req,
  input  logic [AW-1:0] loc_rd_addr,
  input  logic          loc_wr_req,
  input  logic [AW-1:0] loc_wr_addr,
  input  logic [DW-1:0] loc_wr_data,
  output logic          loc_busy,
  output logic          loc_done,
  output logic [DW-1:0] rd_buf,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_vld,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_vld,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdata_vld
);
  rgm_state_t    state;
  logic          accept, advance, defer_vld, cur_is_wr;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;

  assign loc_busy = (state != ST_IDLE);

  rgm_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (loc_rd_req | loc_wr_req),
    .gnt       (bus_gnt),
    .defer_vld (defer_vld),
    .state     (state),
    .accept    (accept),
    .advance   (advance)
  );

  rgm_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .advance   (advance),
    .rd_req    (loc_rd_req),
    .rd_addr   (loc_rd_addr),
    .wr_req    (loc_wr_req),
    .wr_addr   (loc_wr_addr),
    .wr_data   (loc_wr_data),
    .cur_is_wr (cur_is_wr),
    .cur_addr  (cur_addr),
    .cur_data  (cur_data),
    .defer_vld (defer_vld)
  );

  rgm_bus_drv #(.AW(AW), .DW(DW)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cur_is_wr (cur_is_wr),
    .cur_addr  (cur_addr),
    .cur_data  (cur_data),
    .rdata     (bus_rdata),
    .rdata_vld (bus_rdata_vld),
    .req       (bus_req),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .addr_vld  (bus_addr_vld),
    .wdata     (bus_wdata),
    .wdata_vld (bus_wdata_vld),
    .done      (loc_done),
    .rbuf      (rd_buf)
  );
endmodule

// File: rtl/rgm_master_chk.sv
module rgm_master_chk #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loc_done,
  input logic [DW-1:0] rd_buf,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_addr_vld,
  input logic          bus_wdata_vld,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_rdata_vld
);
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  a_r3_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> ($past(bus_gnt) && $past(bus_req, 2)));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r5_addr_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_addr_vld);

  a_r5_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !bus_addr_vld);

  a_r6_wdata_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> bus_wdata_vld);

  a_r6_wdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !bus_wdata_vld);

  a_r7_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && bus_rdata_vld) |=> (rd_buf == $past(bus_rdata)));

  a_r8_no_cmd_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req) && !bus_gnt) |=> !(bus_rd || bus_wr));

  a_r8_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req) && !bus_gnt) |-> ##2 bus_req);

  a_r11_done_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_vld |=> loc_done);

  a_r11_done_only_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr_vld |=> !loc_done);
endmodule

bind rgm_master rgm_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .loc_done      (loc_done),
  .rd_buf        (rd_buf),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_addr_vld  (bus_addr_vld),
  .bus_wdata_vld (bus_wdata_vld),
  .bus_rdata     (bus_rdata),
  .bus_rdata_vld (bus_rdata_vld)
);

// File: tb/sim_rgm_master.sv
module sim_rgm_master;
  localparam int AW = 8;
  localparam int DW = 64;

  typedef struct {
    bit            is_rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;

  logic          clk, rst_n;
  logic          loc_rd_req, loc_wr_req;
  logic [AW-1:0] loc_rd_addr, loc_wr_addr;
  logic [DW-1:0] loc_wr_data;
  logic          loc_busy, loc_done;
  logic [DW-1:0] rd_buf;
  logic          bus_req, bus_gnt, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic          bus_addr_vld, bus_wdata_vld, bus_rdata_vld;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int total = 0;
  int bad = 0;
  int beats = 0;
  int req_cnt = 0;
  bit drop_next = 0;
  item_t exq[$];

  rgm_master #(.AW(AW), .DW(DW)) u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return {8{a}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus model: grant and read data half a cycle ahead of the sampling edge
  logic req_seen, rd_seen;
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 0; bus_rdata_vld <= 0; bus_rdata <= '0;
      req_seen <= 0; rd_seen <= 0;
    end else begin
      if (req_seen && drop_next) begin
        bus_gnt <= 0;
        drop_next <= 0;
      end else begin
        bus_gnt <= req_seen;
      end
      bus_rdata_vld <= rd_seen;
      bus_rdata     <= rd_seen ? mem_val(bus_addr) : '0;
      req_seen <= bus_req;
      rd_seen  <= bus_rd;
    end
  end

  // monitor / scoreboard
  bit prev_rd, prev_wr, prev_beat, prev_beat_rd;
  logic [AW-1:0] prev_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req) req_cnt++;
      if (loc_done || prev_beat)
        chk(loc_done == prev_beat, "R11 done pulse", loc_done, prev_beat);
      if (loc_done && prev_beat_rd)
        chk(rd_buf == mem_val(prev_addr), "R7 read buffer", rd_buf, mem_val(prev_addr));
      if (bus_addr_vld) begin
        beats++;
        if (exq.size() == 0) begin
          chk(0, "R9 unexpected beat", bus_addr, 0);
        end else begin
          item_t it;
          it = exq.pop_front();
          chk(bus_addr == it.a, "R5 address", bus_addr, it.a);
          chk(prev_rd == it.is_rd && prev_wr == !it.is_rd, "R10 op order",
              {prev_rd, prev_wr}, {it.is_rd, !it.is_rd});
          if (!it.is_rd) begin
            chk(bus_wdata_vld && bus_wdata == it.d, "R6 write beat", bus_wdata, it.d);
          end
        end
      end
      prev_beat    = bus_addr_vld;
      prev_beat_rd = bus_addr_vld && prev_rd;
      prev_addr    = bus_addr;
      prev_rd      = bus_rd;
      prev_wr      = bus_wr;
    end
  end

  task automatic issue(bit rd, bit wr, logic [AW-1:0] ra, logic [AW-1:0] wa,
                       logic [DW-1:0] wd, bit expect_taken);
    item_t it;
    if (expect_taken) begin
      while (loc_busy) @(negedge clk);
      if (rd) begin it.is_rd = 1; it.a = ra; it.d = '0; exq.push_back(it); end
      if (wr) begin it.is_rd = 0; it.a = wa; it.d = wd; exq.push_back(it); end
    end
    loc_rd_req = rd; loc_rd_addr = ra;
    loc_wr_req = wr; loc_wr_addr = wa; loc_wr_data = wd;
    @(negedge clk);
    loc_rd_req = 0; loc_wr_req = 0;
    if (expect_taken) chk(loc_busy, "R9 busy after accept", loc_busy, 1);
  endtask

  task automatic drain();
    while (loc_busy || exq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run();
    int b0, r0;
    rst_n = 0;
    loc_rd_req = 0; loc_wr_req = 0;
    loc_rd_addr = '0; loc_wr_addr = '0; loc_wr_data = '0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_rd && !bus_wr && !bus_addr_vld && !bus_wdata_vld,
        "R1 bus idle in reset", {bus_req, bus_rd, bus_wr, bus_addr_vld}, 0);
    chk(!loc_busy && !loc_done && rd_buf == '0, "R1 local idle in reset", rd_buf, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R5 R7: plain read
    issue(1, 0, 8'h10, 8'h00, '0, 1); drain();
    // R6: plain write
    issue(0, 1, 8'h00, 8'h22, 64'hDEAD_BEEF_0000_1111, 1); drain();
    // R10: simultaneous, read goes first
    b0 = beats;
    issue(1, 1, 8'h33, 8'h44, 64'hCAFE_F00D_1234_5678, 1); drain();
    chk(beats - b0 == 2, "R10 both ops ran", beats - b0, 2);
    // R8: missing grant, retry
    r0 = req_cnt; b0 = beats;
    drop_next = 1;
    issue(1, 0, 8'h55, 8'h00, '0, 1); drain();
    chk(req_cnt - r0 == 2, "R8 request repeated", req_cnt - r0, 2);
    chk(beats - b0 == 1, "R8 single transfer", beats - b0, 1);
    // R9: requests while busy are dropped
    b0 = beats;
    issue(0, 1, 8'h00, 8'h66, 64'h6666_0000_6666_0000, 1);
    issue(1, 0, 8'h77, 8'h00, '0, 0);
    issue(0, 1, 8'h00, 8'h78, 64'h1, 0);
    drain();
    chk(beats - b0 == 1, "R9 busy drops requests", beats - b0, 1);
    // back-to-back mix
    for (int i = 0; i < 6; i++) begin
      issue(i[0], !i[0] || i == 4, 8'(8'h80 + i), 8'(8'hC0 + i), {8{8'(i)}}, 1);
    end
    drain();
    chk(exq.size() == 0, "R10 queue drained", exq.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule